// File: doc/BRIEF.md
# Stack Distance Profiling Counter Unit

This block observes a stream of accesses aimed at a single cache set, or at a fully associative structure, with `WAYS` ways under least-recently-used replacement. It keeps its own recency stack of tags. For every access it works out how deep in that stack the tag sits. Each stack depth has its own hit counter, and a separate counter records accesses that match no stored tag. One profiling run therefore shows where temporal reuse falls across the recency depths.

The counters are read through an indexed port that has one cycle of latency. A second indexed port takes a smaller associativity A' and returns the miss count that an LRU structure with only A' ways would have produced. That count is the miss counter plus every hit counter at depth A' or deeper. A synchronous clear empties the stack and zeroes all counters in one cycle, so a new profiling window can start at any time.

Top module: `sdp_counter_unit`

## Requirements
- R1: After reset, or one cycle after `clr` is high, every counter reads 0 and the recency stack holds no valid tag, so the next access is a miss.
- R2: An access whose tag matches no valid stack entry increments only the miss counter, which is at read index `WAYS`.
- R3: An access that matches the stack entry at depth i increments only hit counter i. Depth 0 is the most recently used entry and depth `WAYS-1` is the least recently used.
- R4: On a hit at depth i, the tag moves to depth 0, the entries at depths 0..i-1 move one step deeper, and the entries deeper than i keep their places.
- R5: On a miss, the tag is inserted at depth 0, every entry moves one step deeper, and the entry at depth `WAYS-1` is discarded.
- R6: Counters saturate at 2^`CNT_W`-1 and never wrap.
- R7: `rd_data` shows the counter selected by `rd_idx` one cycle after `rd_idx` is applied. Indices 0..`WAYS-1` select hit counters, `WAYS` selects the miss counter, and any larger index reads 0.
- R8: `qry_miss` shows, one cycle after `qry_ways`=A' is applied, the miss counter plus the sum of hit counters at depths A'..`WAYS-1`. An A' of `WAYS` or more gives the miss counter alone, and an A' of 0 gives the total number of counted accesses.
- R9: When `clr` and `acc_vld` are high in the same cycle, the clear wins and the access is neither counted nor stored.
- R10: Cycles with `acc_vld` low leave both the counters and the stack unchanged, whatever value `acc_tag` has.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the counters and the stack |
| acc_vld | input | 1 | Access strobe |
| acc_tag | input | TAG_W | Tag of the access |
| rd_idx | input | IDX_W | Counter select for the read port |
| rd_data | output | CNT_W | Selected counter value, registered |
| qry_ways | input | IDX_W | Smaller associativity A' to project |
| qry_miss | output | SUM_W | Projected miss count for A', registered |

## Verification
The bench builds the block with four ways, 3-bit tags and 6-bit counters. The eight possible tags against four stack entries give a close mix of hits at every depth, misses, and evictions of tags that come back later. With 6-bit counters, saturation at 63 is reached in a few dozen accesses. An index width of three bits also leaves room for out-of-range read indices and for queries with A' above the way count.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

    localparam int unsigned DEF_WAYS  = 8;
    localparam int unsigned DEF_TAG_W = 12;
    localparam int unsigned DEF_CNT_W = 16;

    // bits needed to carry a value in 0..ways
    function automatic int unsigned idx_width(input int unsigned ways);
        return (ways < 1) ? 1 : $clog2(ways + 1);
    endfunction

    // width of a sum of ways+1 counters of cnt_w bits
    function automatic int unsigned sum_width(input int unsigned ways, input int unsigned cnt_w);
        return cnt_w + $clog2(ways + 1);
    endfunction

endpackage

// File: rtl/sdp_recency_stack.sv
module sdp_recency_stack #(
    parameter int unsigned WAYS  = 8,
    parameter int unsigned TAG_W = 12,
    parameter int unsigned POS_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             acc_vld,
    input  logic [TAG_W-1:0] acc_tag,
    output logic             lk_hit,
    output logic [POS_W-1:0] lk_pos
);

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
    } entry_t;

    entry_t            stk_q [WAYS];
    logic [WAYS-1:0]   match;
    logic [WAYS-1:0]   vld_vec;
    logic [POS_W-1:0]  shift_lim;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g]   = stk_q[g].vld && (stk_q[g].tag == acc_tag);
        assign vld_vec[g] = stk_q[g].vld;
    end

    always_comb begin
        lk_pos = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (match[i]) lk_pos = POS_W'(i);
        end
        lk_hit    = |match;
        shift_lim = lk_hit ? lk_pos : POS_W'(WAYS - 1);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < WAYS; i++) stk_q[i] <= '0;
        end else if (acc_vld) begin
            stk_q[0] <= '{vld: 1'b1, tag: acc_tag};
            for (int i = 1; i < WAYS; i++) begin
                if (POS_W'(i) <= shift_lim) stk_q[i] <= stk_q[i-1];
            end
        end
    end

    for (genvar g = 1; g < WAYS; g++) begin : g_chk
        AST_VALID_PREFIX: assert property (@(posedge clk) disable iff (rst)
            vld_vec[g] |-> vld_vec[g-1]); // R5
    end

    AST_UNIQUE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match)); // R3

    AST_MRU_LOAD: assert property (@(posedge clk) disable iff (rst)
        (acc_vld && !clr) |=> (stk_q[0].vld && stk_q[0].tag == $past(acc_tag))); // R4

    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (rst)
        clr |=> (vld_vec == '0)); // R1

endmodule

// File: rtl/sdp_counter_bank.sv
module sdp_counter_bank #(
    parameter int unsigned WAYS  = 8,
    parameter int unsigned CNT_W = 16,
    parameter int unsigned IDX_W = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr,
    input  logic                        inc_vld,
    input  logic [IDX_W-1:0]            inc_idx,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [CNT_W-1:0]            rd_data,
    output logic [(WAYS+1)*CNT_W-1:0]   cnt_flat
);

    localparam int unsigned NCNT = WAYS + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q [NCNT];
    logic [CNT_W-1:0] rd_sel;

    for (genvar k = 0; k < NCNT; k++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                cnt_q[k] <= '0;
            end else if (inc_vld && inc_idx == IDX_W'(k) && cnt_q[k] != CNT_MAX) begin
                cnt_q[k] <= cnt_q[k] + 1'b1;
            end
        end

        assign cnt_flat[k*CNT_W +: CNT_W] = cnt_q[k];

        AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
            !clr |=> cnt_q[k] >= $past(cnt_q[k])); // R6

        AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
            !clr |=> {1'b0, cnt_q[k]} <= {1'b0, $past(cnt_q[k])} + (CNT_W+1)'(1)); // R3

        AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
            clr |=> cnt_q[k] == '0); // R1
    end

    always_comb begin
        rd_sel = '0;
        for (int k = 0; k < NCNT; k++) begin
            if (rd_idx == IDX_W'(k)) rd_sel = cnt_q[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_data <= '0;
        else     rd_data <= rd_sel;
    end

endmodule

// File: rtl/sdp_miss_projector.sv
module sdp_miss_projector #(
    parameter int unsigned WAYS  = 8,
    parameter int unsigned CNT_W = 16,
    parameter int unsigned IDX_W = 4,
    parameter int unsigned SUM_W = 20
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [(WAYS+1)*CNT_W-1:0]   cnt_flat,
    input  logic [IDX_W-1:0]            qry_ways,
    output logic [SUM_W-1:0]            qry_miss
);

    logic [SUM_W-1:0] sum_c;

    always_comb begin
        sum_c = '0;
        for (int k = 0; k <= WAYS; k++) begin
            if (k == WAYS || IDX_W'(k) >= qry_ways) begin
                sum_c = sum_c + SUM_W'(cnt_flat[k*CNT_W +: CNT_W]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) qry_miss <= '0;
        else     qry_miss <= sum_c;
    end

    AST_PROJ_FLOOR: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> qry_miss >= SUM_W'($past(cnt_flat[WAYS*CNT_W +: CNT_W]))); // R8

endmodule

// File: rtl/sdp_counter_unit.sv
module sdp_counter_unit
    import sdp_pkg::*;
#(
    parameter int unsigned WAYS  = DEF_WAYS,
    parameter int unsigned TAG_W = DEF_TAG_W,
    parameter int unsigned CNT_W = DEF_CNT_W,
    parameter int unsigned IDX_W = idx_width(WAYS),
    parameter int unsigned SUM_W = sum_width(WAYS, CNT_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             acc_vld,
    input  logic [TAG_W-1:0] acc_tag,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_data,
    input  logic [IDX_W-1:0] qry_ways,
    output logic [SUM_W-1:0] qry_miss
);

    localparam logic [IDX_W-1:0] MISS_IDX = IDX_W'(WAYS);

    logic                        lk_hit;
    logic [IDX_W-1:0]            lk_pos;
    logic                        inc_vld;
    logic [IDX_W-1:0]            inc_idx;
    logic [(WAYS+1)*CNT_W-1:0]   cnt_flat;

    assign inc_vld = acc_vld && !clr;
    assign inc_idx = lk_hit ? lk_pos : MISS_IDX;

    sdp_recency_stack #(.WAYS(WAYS), .TAG_W(TAG_W), .POS_W(IDX_W)) u_stack (
        .clk(clk), .rst(rst), .clr(clr),
        .acc_vld(acc_vld), .acc_tag(acc_tag),
        .lk_hit(lk_hit), .lk_pos(lk_pos)
    );

    sdp_counter_bank #(.WAYS(WAYS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst(rst), .clr(clr),
        .inc_vld(inc_vld), .inc_idx(inc_idx),
        .rd_idx(rd_idx), .rd_data(rd_data), .cnt_flat(cnt_flat)
    );

    sdp_miss_projector #(.WAYS(WAYS), .CNT_W(CNT_W), .IDX_W(IDX_W), .SUM_W(SUM_W)) u_proj (
        .clk(clk), .rst(rst), .cnt_flat(cnt_flat),
        .qry_ways(qry_ways), .qry_miss(qry_miss)
    );

    AST_HIT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> lk_pos < MISS_IDX); // R3

endmodule

// File: tb/sdp_counter_unit_tb.sv
`timescale 1ns/1ps
module sdp_counter_unit_tb_top;

    localparam int WAYS  = 4;
    localparam int TAG_W = 3;
    localparam int CNT_W = 6;
    localparam int IDX_W = 3;
    localparam int SUM_W = 9;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             clr = 1'b0;
    logic             acc_vld = 1'b0;
    logic [TAG_W-1:0] acc_tag = '0;
    logic [IDX_W-1:0] rd_idx = '0;
    logic [CNT_W-1:0] rd_data;
    logic [IDX_W-1:0] qry_ways = '0;
    logic [SUM_W-1:0] qry_miss;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    bit done  = 0;

    int m_tag [WAYS];
    bit m_vld [WAYS];
    int m_cnt [WAYS+1];

    always #2 clk = ~clk;

    sdp_counter_unit #(.WAYS(WAYS), .TAG_W(TAG_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .SUM_W(SUM_W)) dut_i (
        .clk(clk), .rst(rst), .clr(clr), .acc_vld(acc_vld), .acc_tag(acc_tag),
        .rd_idx(rd_idx), .rd_data(rd_data), .qry_ways(qry_ways), .qry_miss(qry_miss)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic void model_clear();
        for (int i = 0; i < WAYS; i++) begin m_vld[i] = 0; m_tag[i] = 0; end
        for (int i = 0; i <= WAYS; i++) m_cnt[i] = 0;
    endfunction

    function automatic int model_pos(int tag);
        for (int i = 0; i < WAYS; i++) if (m_vld[i] && m_tag[i] == tag) return i;
        return -1;
    endfunction

    function automatic void model_access(int tag);
        int pos = model_pos(tag);
        int idx = (pos < 0) ? WAYS : pos;
        int lim = (pos < 0) ? WAYS - 1 : pos;
        if (m_cnt[idx] < CMAX) m_cnt[idx]++;
        for (int i = lim; i >= 1; i--) begin m_tag[i] = m_tag[i-1]; m_vld[i] = m_vld[i-1]; end
        m_tag[0] = tag; m_vld[0] = 1;
    endfunction

    function automatic int model_proj(int q);
        int s = 0;
        for (int k = 0; k <= WAYS; k++) if (k == WAYS || k >= q) s += m_cnt[k];
        return s;
    endfunction

    task automatic access(int tag);
        @(negedge clk); acc_vld = 1'b1; acc_tag = TAG_W'(tag);
        @(posedge clk); model_access(tag);
        @(negedge clk); acc_vld = 1'b0;
    endtask

    task automatic do_clear(bit with_acc, int tag);
        @(negedge clk); clr = 1'b1; acc_vld = with_acc; acc_tag = TAG_W'(tag);
        @(posedge clk); model_clear();
        @(negedge clk); clr = 1'b0; acc_vld = 1'b0;
    endtask

    task automatic read_cnt(int idx, output int val);
        @(negedge clk); rd_idx = IDX_W'(idx);
        @(posedge clk);
        @(negedge clk); val = int'(rd_data);
    endtask

    task automatic check_counters(string req);
        int v;
        for (int k = 0; k <= WAYS; k++) begin
            read_cnt(k, v);
            chk(req, v, m_cnt[k]);
        end
    endtask

    task automatic check_proj(string req);
        for (int q = 0; q <= WAYS + 2; q++) begin
            @(negedge clk); qry_ways = IDX_W'(q);
            @(posedge clk);
            @(negedge clk); chk(req, int'(qry_miss), model_proj(q));
        end
    endtask

    initial begin
        int v;
        void'($urandom(32'd20240611));
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state
        check_counters("R1 reset");
        chk("R1 reset proj", int'(qry_miss), 0);

        // R2/R5: cold misses fill the stack
        access(1); access(2); access(3); access(4);
        read_cnt(WAYS, v); chk("R2 cold misses", v, 4);
        // R3: hit at LRU depth 3
        access(1);
        read_cnt(3, v); chk("R3 hit at depth 3", v, 1);
        // R4: stack is now 1,4,3,2; tag 4 sits at depth 1
        access(4);
        read_cnt(1, v); chk("R4 shift after hit", v, 1);
        access(3);
        read_cnt(2, v); chk("R4 deeper entry kept", v, 1);
        // R5: stack 3,4,1,2; miss 5 drops 2, so 2 misses again
        access(5); access(2);
        read_cnt(WAYS, v); chk("R5 LRU dropped", v, 6);
        check_counters("R3 directed");
        check_proj("R8 directed");

        // R7: out-of-range read indices
        for (int k = WAYS + 1; k < (1 << IDX_W); k++) begin
            read_cnt(k, v); chk("R7 out of range", v, 0);
        end

        // R10: idle cycles with changing tag
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); acc_vld = 1'b0; acc_tag = TAG_W'(i);
        end
        check_counters("R10 idle");
        access(2);
        read_cnt(0, v); chk("R10 stack unchanged", v, 1);

        // R9/R1: clear with simultaneous access
        do_clear(1'b1, 2);
        check_counters("R9 clear wins");
        access(2);
        read_cnt(WAYS, v); chk("R1 empty after clear", v, 1);

        // R6: saturation
        for (int i = 0; i < 70; i++) access(7);
        read_cnt(0, v); chk("R6 saturate", v, CMAX);
        check_proj("R8 saturated");

        // random phases
        for (int ph = 0; ph < 4; ph++) begin
            do_clear(1'b0, 0);
            for (int i = 0; i < 50; i++) begin
                if ($urandom_range(0, 4) == 0) @(negedge clk);
                access(int'($urandom_range(0, (1 << TAG_W) - 1)));
            end
            check_counters("R3 random");
            check_proj("R8 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule